// File: doc/BRIEF.md
# Parallel Interleaver Bank Router

This block sits between a set of parallel processing elements and an equal number of single-port memory banks in an iterative decoder. Each data item lives in one bank word and is visited several times, in an interleaved order, as the decoder runs. On every processing step the router fetches one word per element and, one cycle later, stores that element's result. The read bank and the write bank of an item may differ within the same step. A built-in step table gives, for each element, a read bank, a read address, a write bank and a write address. It also gives a rotate flag and a shift amount for each direction. A step counter walks this table and wraps after the last step, so the table itself forms the control sequence of the interconnect.

A read crossbar routes bank outputs to elements, and a write crossbar routes element results to banks. When a step's bank assignment is a plain circular rotation, a barrel-shift path is used in place of the crossbar select. A step whose read banks or write banks do not cover every bank exactly once is flagged as a collision. The counter is then held on that step and neither a read nor a write is started. The default table is a six-step schedule for three elements and two words per bank. In that schedule items move between banks, and every pass returns each item to its starting word. A second table variant, chosen by parameter, holds a deliberately broken step.

Top module: `ilv_bank_router`

## Requirements
- R1: After reset the step index is 0, every bank word holds 0, every element's read output is 0 and the collision flag is low for the default table.
- R2: On each rising edge where `adv_i` is high and `collide_o` is low, the step index advances by one and wraps from NSTEP-1 to 0. Otherwise it holds its value.
- R3: In the cycle after a step is issued, element p's read output carries the word stored at that step's read bank and read address for p.
- R4: The element data presented in the cycle after a step is issued is stored at the next rising edge into that step's write bank and write address for each element, even when the write bank differs from the read bank.
- R5: With the default table, the value an element reads for an item always equals the last value written for that item, across bank moves and across wrap-around of the step index.
- R6: When a step reads a word that the previous step's write is storing on the same edge, the new value is returned.
- R7: A step whose table entry marks a direction as rotated has, for every element p, bank index (p + shift) mod NPE in that direction.
- R8: When the current step's read banks or write banks are not a permutation of 0..NPE-1, `collide_o` is high, the step index holds while `adv_i` is high, and no read or write is started.
- R9: Element data presented in a cycle that does not follow an issued step changes no bank word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Request to issue the current step |
| wr_data_i | input | NPE*W | Results from the elements, element p in bits [p*W +: W] |
| rd_data_o | output | NPE*W | Fetched words for the elements, element p in bits [p*W +: W] |
| step_o | output | SW | Current step index |
| collide_o | output | 1 | Current step's bank assignment is not a permutation |

## Verification
The assertions take for granted that a step is started only when its table entry is a clean permutation. A write therefore never finds two elements aimed at one bank, and a rotate flag in the table always matches the bank indices it stands for. The stimulus keeps inside these limits. The regular instance gets a legal table, with `adv_i` driven high and low at random after a directed run of back-to-back steps that exercises the same-edge forwarding case. The only broken entry is given to a second instance, which is checked for the flag and the hold.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef struct packed {
        logic [7:0] rb;
        logic [7:0] ra;
        logic [7:0] wb;
        logic [7:0] wa;
    } slot_t;

    typedef struct packed {
        logic       rrot;
        logic [7:0] rsh;
        logic       wrot;
        logic [7:0] wsh;
    } turn_t;

    // Built-in schedule: per step and element, bank and word for both directions.
    function automatic slot_t slot_at(int sel, int npe, int depth, int nstep,
                                      int step, int pe);
        slot_t s;
        int rb, ra, wb, wa;
        rb = 0; ra = 0; wb = 0; wa = 0;
        if (npe == 3 && depth == 2 && nstep == 6) begin
            case (step * 3 + pe)
                0:  begin rb = 0; ra = 0; wb = 1; wa = 0; end
                1:  begin rb = 1; ra = 0; wb = 2; wa = 0; end
                2:  begin rb = 2; ra = 0; wb = 0; wa = 0; end
                3:  begin rb = 1; ra = 1; wb = 1; wa = 1; end
                4:  begin rb = 2; ra = 1; wb = 2; wa = 1; end
                5:  begin rb = 0; ra = 1; wb = 0; wa = 1; end
                6:  begin rb = 2; ra = 0; wb = 2; wa = 0; end
                7:  begin rb = 1; ra = 0; wb = 0; wa = 0; end
                8:  begin rb = 0; ra = 0; wb = 1; wa = 0; end
                9:  begin rb = 2; ra = 1; wb = 2; wa = 1; end
                10: begin rb = 0; ra = 1; wb = 0; wa = 1; end
                11: begin rb = 1; ra = 0; wb = 1; wa = 0; end
                12: begin rb = 2; ra = 0; wb = 1; wa = 0; end
                13: begin rb = 1; ra = 0; wb = 2; wa = 0; end
                14: begin rb = 0; ra = 1; wb = 0; wa = 1; end
                15: begin rb = 0; ra = 0; wb = 0; wa = 0; end
                16: begin rb = 1; ra = 1; wb = 1; wa = 1; end
                default: begin rb = 2; ra = 1; wb = 2; wa = 1; end
            endcase
            if (sel == 1 && step == 2 && pe == 2) wb = 0;
        end else begin
            rb = (pe + step) % npe;
            ra = step % depth;
            wb = rb;
            wa = ra;
        end
        s.rb = 8'(rb);
        s.ra = 8'(ra);
        s.wb = 8'(wb);
        s.wa = 8'(wa);
        return s;
    endfunction

    // Rotation flags and shift amounts per step.
    function automatic turn_t turn_at(int sel, int npe, int depth, int nstep, int step);
        turn_t t;
        t.rrot = 1'b1;
        t.wrot = 1'b1;
        t.rsh  = 8'(step % npe);
        t.wsh  = 8'(step % npe);
        if (npe == 3 && depth == 2 && nstep == 6) begin
            case (step)
                0: begin t.rrot = 1'b1; t.rsh = 8'd0; t.wrot = 1'b1; t.wsh = 8'd1; end
                1: begin t.rrot = 1'b1; t.rsh = 8'd1; t.wrot = 1'b1; t.wsh = 8'd1; end
                2: begin t.rrot = 1'b0; t.rsh = 8'd0; t.wrot = (sel != 1); t.wsh = 8'd2; end
                3: begin t.rrot = 1'b1; t.rsh = 8'd2; t.wrot = 1'b1; t.wsh = 8'd2; end
                4: begin t.rrot = 1'b0; t.rsh = 8'd0; t.wrot = 1'b1; t.wsh = 8'd1; end
                default: begin t.rrot = 1'b1; t.rsh = 8'd0; t.wrot = 1'b1; t.wsh = 8'd0; end
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int W     = 8,
    parameter int DEPTH = 2,
    parameter int AW    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [W-1:0]            rd;
    } bank_st_t;

    bank_st_t q, d;

    always_comb begin
        d = q;
        if (we) d.mem[waddr] = wdata;
        if (re) d.rd = (we && waddr == raddr) ? wdata : q.mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.rd;

    // R6
    fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && we && raddr == waddr) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/ilv_route.sv
module ilv_route #(
    parameter int N           = 3,
    parameter int W           = 8,
    parameter int BW          = 2,
    parameter bit HAS_SHIFTER = 1'b1
) (
    input  logic [N-1:0][W-1:0]  in,
    input  logic [N-1:0][BW-1:0] sel,
    input  logic                 rot,
    input  logic [BW-1:0]        sh,
    output logic [N-1:0][W-1:0]  out
);

    for (genvar o = 0; o < N; o++) begin : g_out
        logic [BW-1:0] idx;
        if (HAS_SHIFTER) begin : g_shift
            always_comb begin
                int s;
                s = o + int'(sh);
                if (s >= N) s = s - N;
                idx = rot ? BW'(s) : sel[o];
            end
        end else begin : g_xbar
            always_comb idx = sel[o];
        end
        assign out[o] = in[idx];
    end

endmodule

// File: rtl/ilv_sched.sv
module ilv_sched #(
    parameter int NPE   = 3,
    parameter int DEPTH = 2,
    parameter int NSTEP = 6,
    parameter int SEL   = 0,
    parameter int BW    = 2,
    parameter int AW    = 1,
    parameter int SW    = 3
) (
    input  logic [SW-1:0]          step,
    output logic [NPE-1:0][BW-1:0] rb,
    output logic [NPE-1:0][AW-1:0] ra,
    output logic [NPE-1:0][BW-1:0] wb,
    output logic [NPE-1:0][AW-1:0] wa,
    output logic                   rrot,
    output logic [BW-1:0]          rsh,
    output logic                   wrot,
    output logic [BW-1:0]          wsh,
    output logic                   collide
);
    import ilv_pkg::*;

    always_comb begin
        logic [NPE-1:0] rmask, wmask;
        logic           bad;
        slot_t          s;
        turn_t          t;
        rmask = '0;
        wmask = '0;
        bad   = 1'b0;
        t     = turn_at(SEL, NPE, DEPTH, NSTEP, int'(step));
        rrot  = t.rrot;
        wrot  = t.wrot;
        rsh   = t.rsh[BW-1:0];
        wsh   = t.wsh[BW-1:0];
        for (int p = 0; p < NPE; p++) begin
            s     = slot_at(SEL, NPE, DEPTH, NSTEP, int'(step), p);
            rb[p] = s.rb[BW-1:0];
            ra[p] = s.ra[AW-1:0];
            wb[p] = s.wb[BW-1:0];
            wa[p] = s.wa[AW-1:0];
            if (int'(s.rb) >= NPE) bad = 1'b1;
            else                   rmask[s.rb[BW-1:0]] = 1'b1;
            if (int'(s.wb) >= NPE) bad = 1'b1;
            else                   wmask[s.wb[BW-1:0]] = 1'b1;
        end
        collide = bad || (rmask != '1) || (wmask != '1);
    end

endmodule

// File: rtl/ilv_bank_router.sv
module ilv_bank_router #(
    parameter int NPE         = 3,
    parameter int W           = 8,
    parameter int DEPTH       = 2,
    parameter int NSTEP       = 6,
    parameter int SEL         = 0,
    parameter bit HAS_SHIFTER = 1'b1,
    localparam int BW = (NPE > 1) ? $clog2(NPE) : 1,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [NPE*W-1:0] wr_data_i,
    output logic [NPE*W-1:0] rd_data_o,
    output logic [SW-1:0]    step_o,
    output logic             collide_o
);

    typedef struct packed {
        logic [SW-1:0]          step;
        logic                   wv;
        logic [NPE-1:0][BW-1:0] rsel;
        logic                   rrot;
        logic [BW-1:0]          rsh;
        logic [NPE-1:0][BW-1:0] wb;
        logic [NPE-1:0][AW-1:0] wa;
        logic                   wrot;
        logic [BW-1:0]          wsh;
    } st_t;

    st_t q, d;

    logic [NPE-1:0][BW-1:0] s_rb, s_wb;
    logic [NPE-1:0][AW-1:0] s_ra, s_wa;
    logic                   s_rrot, s_wrot, s_coll;
    logic [BW-1:0]          s_rsh, s_wsh;
    logic                   issue;

    ilv_sched #(.NPE(NPE), .DEPTH(DEPTH), .NSTEP(NSTEP), .SEL(SEL),
                .BW(BW), .AW(AW), .SW(SW)) u_sched (
        .step(q.step), .rb(s_rb), .ra(s_ra), .wb(s_wb), .wa(s_wa),
        .rrot(s_rrot), .rsh(s_rsh), .wrot(s_wrot), .wsh(s_wsh),
        .collide(s_coll)
    );

    assign issue = adv_i && !s_coll;

    always_comb begin
        d    = q;
        d.wv = issue;
        if (issue) begin
            d.step = (q.step == SW'(NSTEP - 1)) ? '0 : q.step + SW'(1);
            d.rsel = s_rb;
            d.rrot = s_rrot;
            d.rsh  = s_rsh;
            d.wb   = s_wb;
            d.wa   = s_wa;
            d.wrot = s_wrot;
            d.wsh  = s_wsh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Inverse maps: which element feeds each bank, in both directions.
    logic [NPE-1:0][BW-1:0] rsrc, wsrc;
    logic [BW-1:0]          rish, wish;

    always_comb begin
        for (int b = 0; b < NPE; b++) begin
            rsrc[b] = '0;
            wsrc[b] = '0;
            for (int p = 0; p < NPE; p++) begin
                if (s_rb[p] == BW'(b)) rsrc[b] = BW'(p);
                if (q.wb[p] == BW'(b)) wsrc[b] = BW'(p);
            end
        end
        rish = (s_rsh == '0) ? '0 : BW'(NPE - int'(s_rsh));
        wish = (q.wsh == '0) ? '0 : BW'(NPE - int'(q.wsh));
    end

    logic [NPE-1:0][AW-1:0] bank_raddr, bank_waddr;
    logic [NPE-1:0][W-1:0]  bank_wdata, bank_rdata, pe_wdata, pe_rdata;

    assign pe_wdata = wr_data_i;

    ilv_route #(.N(NPE), .W(AW), .BW(BW), .HAS_SHIFTER(HAS_SHIFTER)) u_raddr (
        .in(s_ra), .sel(rsrc), .rot(s_rrot), .sh(rish), .out(bank_raddr));
    ilv_route #(.N(NPE), .W(AW), .BW(BW), .HAS_SHIFTER(HAS_SHIFTER)) u_waddr (
        .in(q.wa), .sel(wsrc), .rot(q.wrot), .sh(wish), .out(bank_waddr));
    ilv_route #(.N(NPE), .W(W), .BW(BW), .HAS_SHIFTER(HAS_SHIFTER)) u_wdata (
        .in(pe_wdata), .sel(wsrc), .rot(q.wrot), .sh(wish), .out(bank_wdata));
    ilv_route #(.N(NPE), .W(W), .BW(BW), .HAS_SHIFTER(HAS_SHIFTER)) u_rdata (
        .in(bank_rdata), .sel(q.rsel), .rot(q.rrot), .sh(q.rsh), .out(pe_rdata));

    for (genvar b = 0; b < NPE; b++) begin : g_bank
        ilv_bank #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .re(issue), .raddr(bank_raddr[b]),
            .we(q.wv), .waddr(bank_waddr[b]), .wdata(bank_wdata[b]),
            .rdata(bank_rdata[b]));
    end

    assign rd_data_o = pe_rdata;
    assign step_o    = q.step;
    assign collide_o = s_coll;

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (q.step == (($past(q.step) == SW'(NSTEP - 1)) ? '0
                                : SW'($past(q.step) + SW'(1)))));

    // R8
    coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && collide_o) |=> ($stable(q.step) && !q.wv));

    // R4
    logic [NPE-1:0] wmask_q;
    always_comb begin
        wmask_q = '0;
        for (int p = 0; p < NPE; p++) wmask_q[q.wb[p]] = 1'b1;
    end
    wr_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wv |-> ($countones(wmask_q) == NPE));

    for (genvar p = 0; p < NPE; p++) begin : g_rot_chk
        // R7
        rot_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_rrot |-> (int'(s_rb[p]) == ((p + int'(s_rsh)) % NPE)));
        // R7
        wrot_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_wrot |-> (int'(s_wb[p]) == ((p + int'(s_wsh)) % NPE)));
    end

endmodule

// File: tb/sim_ilv_bank_router.sv
module sim_ilv_bank_router;

    localparam int NPE = 3;
    localparam int W   = 8;
    localparam int NS  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             adv0 = 1'b0, adv1 = 1'b0;
    logic [NPE*W-1:0] wr_data = '0;
    logic [NPE*W-1:0] rd0, rd1;
    logic [2:0]       step0, step1;
    logic             coll0, coll1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ilv_bank_router #(.SEL(0)) u0 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv0), .wr_data_i(wr_data),
        .rd_data_o(rd0), .step_o(step0), .collide_o(coll0));

    ilv_bank_router #(.SEL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv1), .wr_data_i(wr_data),
        .rd_data_o(rd1), .step_o(step1), .collide_o(coll1));

    // Item visited by element p at step t (access order of the schedule).
    function automatic int item_of(int t, int p);
        case (t * 3 + p)
            0: return 0;  1: return 1;  2: return 2;
            3: return 4;  4: return 5;  5: return 3;
            6: return 1;  7: return 0;  8: return 2;
            9: return 5;  10: return 3; 11: return 2;
            12: return 1; 13: return 2; 14: return 3;
            15: return 0; 16: return 4; default: return 5;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit in_step(int t, int it);
        for (int p = 0; p < NPE; p++) if (item_of(t, p) == it) return 1'b1;
        return 1'b0;
    endfunction

    bit done = 1'b0;

    initial begin
        int  val [6];
        int  s, prev_t, k;
        bit  issued, prev_issued, prev_idle;
        string tag;
        process::self().srandom(32'd7);
        for (int i = 0; i < 6; i++) val[i] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", int'(step0), 0);
        check("R1", int'(coll0), 0);
        check("R1", int'(rd0), 0);
        check("R1", int'(step1), 0);

        s = 0; prev_t = -1; prev_issued = 0; prev_idle = 0; k = 0;
        adv0 = 1'b1;
        adv1 = 1'b1;
        for (int it = 0; it < 80; it++) begin
            @(posedge clk);
            issued = adv0;
            k++;
            @(negedge clk);
            if (issued) begin
                // Reads check R3 placement, R4 late write, R5 item consistency.
                for (int p = 0; p < NPE; p++) begin
                    int itm;
                    itm = item_of(s, p);
                    if (prev_idle) tag = "R9";
                    else if (prev_issued && prev_t >= 0 && in_step(prev_t, itm)) tag = "R6";
                    else if (p == 0) tag = "R3";
                    else tag = "R5";
                    check(tag, int'(rd0[p*W +: W]), val[itm]);
                end
                for (int p = 0; p < NPE; p++) begin
                    logic [W-1:0] v;
                    v = W'($urandom);
                    wr_data[p*W +: W] = v;
                    val[item_of(s, p)] = int'(v);
                end
                prev_t = s;
                s = (s + 1) % NS;
                check("R2", int'(step0), s);
                prev_idle = 0;
            end else begin
                wr_data = (NPE*W)'({$urandom, $urandom});
                check("R2", int'(step0), s);
                prev_idle = prev_issued ? 0 : 1;
            end
            prev_issued = issued;
            if (!issued) prev_idle = 1;

            // R8: broken table holds at step 2 with flag raised
            if (k <= 8) begin
                check("R8", int'(step1), (k < 2) ? k : 2);
                check("R8", int'(coll1), (k >= 2) ? 1 : 0);
            end

            adv0 = (it < 14) ? 1'b1 : (($urandom % 4) != 0);
        end
        adv0 = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule